// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Interrupt Capture

A general-purpose I/O port of up to 32 pins, controlled through four word-wide registers on a simple word-addressed bus. Each pin is an input or a driven output, chosen per pin. Software writes the levels to drive and reads back the pin state. Input events on pins that software enables are folded into one interrupt line.

The kind of event is fixed when the block is built. It is one of rising edge, falling edge, either edge, or level-high. In the three edge modes, a detected edge sets a sticky capture bit. Software clears that bit by writing a one to it. In level-high mode there is no capture stage: the interrupt follows the pin data gated by the enable mask.

Pin inputs are resynchronised before any use. The block also holds its own reset synchroniser, so reset assertion is asynchronous and release is aligned to the clock.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero, all output enables are low and the interrupt is low.
- R2: `pin_oe[i]` equals bit i of the direction register (1 = output, 0 = input). `pin_out` equals the last value written to the data register, one cycle after the write.
- R3: A read of the data register returns, per pin, the output register bit for output pins and the synchronised pin level for input pins. A pin change becomes visible two clock edges after it is applied.
- R4: The interrupt mask register is read/write. Register bits at or above PIN_COUNT read zero.
- R5: In rising mode, a 0-to-1 transition on a pin sets its capture bit on the third clock edge after the change. A 1-to-0 transition sets nothing.
- R6: In falling mode, only 1-to-0 transitions set capture bits.
- R7: In both-edges mode, either transition sets the capture bit.
- R8: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged.
- R9: If an edge is detected on the same edge as a clearing write to that bit, the bit stays set.
- R10: In edge modes, `irq` is high exactly when some capture bit and its mask bit are both 1. Masked events are still recorded in the capture register.
- R11: In level mode, `irq` is the OR of (data view AND mask). The capture register reads zero and ignores writes.
- R12: `bus_addr` is a word index: 0 data, 1 direction, 2 mask, 3 capture (byte offsets 0x0, 0x4, 0x8, 0xC).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_en |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | PIN_COUNT | Raw pin levels |
| pin_out | output | PIN_COUNT | Levels to drive |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an edge and a clearing write to the same capture bit landing on the same clock edge. The stimulus first leaves the bit set from an earlier edge. It then lets the pin return low and settle, raises the pin again, and places the clear-write exactly two cycles later. That timing matches the synchroniser and detector delay, so both events meet on the third edge. Four instances, one per trigger mode, share the same stimulus. A single pin sequence therefore shows edges being captured in one mode and ignored in another.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  // Word indices; the byte offsets are four times these.
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_DIR  = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam logic [1:0] ADDR_CAP  = 2'd3;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= raw_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture
  import gpio_pkg::*;
#(
  parameter int    WIDTH   = 32,
  parameter trig_e TRIGGER = TRIG_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] edge_vec,
  output logic [WIDTH-1:0] cap_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cap_d;
  logic [WIDTH-1:0] clr_eff;

  always_comb begin
    case (TRIGGER)
      TRIG_RISE: edge_vec = level_in & ~prev_q;
      TRIG_FALL: edge_vec = ~level_in & prev_q;
      TRIG_BOTH: edge_vec = level_in ^ prev_q;
      default:   edge_vec = '0;
    endcase
  end

  // A detected edge overrides a simultaneous clear so that no event is lost.
  always_comb begin
    clr_eff = clr_en ? clr_bits : '0;
    cap_d   = (cap_q & ~clr_eff) | edge_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= level_in;
      cap_q  <= cap_d;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q
);
  logic [WIDTH-1:0] out_d;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] mask_d;

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    mask_d = mask_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_DATA: out_d  = wr_data;
        ADDR_DIR:  dir_d  = wr_data;
        ADDR_MASK: mask_d = wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIGGER   = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq
);
  localparam int W = PIN_COUNT;

  logic         rst_sync_n;
  logic         wr_en;
  logic         clr_en;
  logic [W-1:0] wdata_pins;
  logic [W-1:0] level_sync;
  logic [W-1:0] out_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] cap_q;
  logic [W-1:0] edge_vec;
  logic [W-1:0] data_view;

  assign wr_en      = bus_en & bus_we;
  assign clr_en     = wr_en & (bus_addr == ADDR_CAP);
  assign wdata_pins = bus_wdata[W-1:0];

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_sync #(.WIDTH(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_in   (pin_in),
    .sync_out (level_sync)
  );

  gpio_regs #(.WIDTH(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (bus_addr),
    .wr_data (wdata_pins),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .mask_q  (mask_q)
  );

  gpio_edge_capture #(.WIDTH(W), .TRIGGER(TRIGGER)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .level_in (level_sync),
    .clr_en   (clr_en),
    .clr_bits (wdata_pins),
    .edge_vec (edge_vec),
    .cap_q    (cap_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? out_q[i] : level_sync[i];
  end

  if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
    assign irq = |(data_view & mask_q);
  end else begin : g_irq_edge
    assign irq = |(cap_q & mask_q);
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = BUS_W'(data_view);
      ADDR_DIR:  bus_rdata = BUS_W'(dir_q);
      ADDR_MASK: bus_rdata = BUS_W'(mask_q);
      default:   bus_rdata = BUS_W'(cap_q);
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIGGER   = TRIG_RISE
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [1:0]           bus_addr,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [PIN_COUNT-1:0] mask_q,
  input logic [PIN_COUNT-1:0] cap_q,
  input logic [PIN_COUNT-1:0] edge_vec,
  input logic                 irq
);
  logic wr_dir, wr_data, wr_mask, wr_cap;
  assign wr_dir  = bus_en && bus_we && (bus_addr == ADDR_DIR);
  assign wr_data = bus_en && bus_we && (bus_addr == ADDR_DATA);
  assign wr_mask = bus_en && bus_we && (bus_addr == ADDR_MASK);
  assign wr_cap  = bus_en && bus_we && (bus_addr == ADDR_CAP);

  a_r2_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_dir |=> (pin_oe == $past(bus_wdata[PIN_COUNT-1:0])));

  a_r2_out_tracks_data: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_data |=> (pin_out == $past(bus_wdata[PIN_COUNT-1:0])));

  a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_mask |=> (mask_q == $past(bus_wdata[PIN_COUNT-1:0])));

  a_r8_clear_ones: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_cap |=> ((cap_q & $past(bus_wdata[PIN_COUNT-1:0] & ~edge_vec)) == '0));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!wr_cap && (edge_vec == '0)) |=> (cap_q == $past(cap_q)));

  a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (edge_vec != '0) |=> ((cap_q & $past(edge_vec)) == $past(edge_vec)));

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> (mask_q != '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PIN_COUNT(PIN_COUNT), .TRIGGER(TRIGGER)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .mask_q    (mask_q),
  .cap_q     (cap_q),
  .edge_vec  (edge_vec),
  .irq       (irq)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  import gpio_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] pin_in;

  logic [31:0] r0, r1, r2, r3;
  logic [31:0] po0, oe0;
  logic [7:0]  po1, oe1, po2, oe2, po3, oe3;
  logic        irq0, irq1, irq2, irq3;

  int n_cmp = 0;
  int n_bad = 0;

  gpio_irq_port #(.PIN_COUNT(32), .TRIGGER(TRIG_RISE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(r0), .pin_in(pin_in), .pin_out(po0), .pin_oe(oe0), .irq(irq0));
  gpio_irq_port #(.PIN_COUNT(8), .TRIGGER(TRIG_FALL)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(r1), .pin_in(pin_in[7:0]), .pin_out(po1), .pin_oe(oe1), .irq(irq1));
  gpio_irq_port #(.PIN_COUNT(8), .TRIGGER(TRIG_BOTH)) u2 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(r2), .pin_in(pin_in[7:0]), .pin_out(po2), .pin_oe(oe2), .irq(irq2));
  gpio_irq_port #(.PIN_COUNT(8), .TRIGGER(TRIG_LEVEL)) u3 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(r3), .pin_in(pin_in[7:0]), .pin_out(po3), .pin_oe(oe3), .irq(irq3));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic point(input logic [1:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_clean();
    bus_write(ADDR_MASK, 32'h0);
    set_pins(32'h0);
    idle(5);
    bus_write(ADDR_CAP, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    point(ADDR_DATA); chk("R1 data", r0, 32'h0);
    point(ADDR_DIR);  chk("R1 dir", r0, 32'h0);
    point(ADDR_MASK); chk("R1 mask", r0, 32'h0);
    point(ADDR_CAP);  chk("R1 cap", r0, 32'h0);
    chk("R1 oe", oe0, 32'h0);
    chk("R1 irq", {28'h0, irq0, irq1, irq2, irq3}, 32'h0);
  endtask

  task automatic t_dir_out();
    bus_write(ADDR_DIR, 32'h0000_00F0);
    chk("R2 oe", oe0, 32'h0000_00F0);
    chk("R2 oe narrow", {24'h0, oe1}, 32'h0000_00F0);
    bus_write(ADDR_DATA, 32'hA5A5_5A5A);
    chk("R2 pin_out", po0, 32'hA5A5_5A5A);
    point(ADDR_DIR); chk("R12 dir index", r0, 32'h0000_00F0);
  endtask

  task automatic t_readback();
    logic [31:0] dirv, outv, pv;
    dirv = 32'h0000_00F0; outv = 32'hA5A5_5A5A; pv = 32'h1234_5603;
    set_pins(pv);
    point(ADDR_DATA);
    idle(1);
    chk("R3 not yet", r0, outv & dirv);
    idle(1);
    chk("R3 view", r0, (outv & dirv) | (pv & ~dirv));
  endtask

  task automatic t_mask();
    bus_write(ADDR_MASK, 32'hFFFF_FFFF);
    point(ADDR_MASK);
    chk("R4 mask full", r0, 32'hFFFF_FFFF);
    chk("R4 mask narrow", r1, 32'h0000_00FF);
    bus_write(ADDR_MASK, 32'h0);
  endtask

  task automatic t_edges();
    settle_clean();
    point(ADDR_CAP);
    chk("R8 all cleared", r0, 32'h0);
    set_pins(32'h1);
    idle(2);
    chk("R5 latency", r0, 32'h0);
    idle(1);
    chk("R5 rise cap", r0, 32'h1);
    chk("R6 fall ignores rise", r1, 32'h0);
    chk("R7 both rise", r2, 32'h1);
    set_pins(32'h0);
    idle(4);
    chk("R5 rise ignores fall", r0, 32'h1);
    chk("R6 fall cap", r1, 32'h1);
    chk("R7 both fall", r2, 32'h1);
    bus_write(ADDR_CAP, 32'hFFFF_FFFF);
    chk("R8 clear u0", r0, 32'h0);
    chk("R8 clear u2", r2, 32'h0);
    set_pins(32'h3);
    idle(4);
    bus_write(ADDR_CAP, 32'h1);
    chk("R8 zero keeps", r2, 32'h2);
    bus_write(ADDR_CAP, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    settle_clean();
    point(ADDR_CAP);
    set_pins(32'h4);
    idle(4);
    set_pins(32'h0);
    idle(4);
    chk("R9 pre set", r0 & 32'h4, 32'h4);
    chk("R9 pre fall", r1 & 32'h4, 32'h4);
    set_pins(32'h4);
    idle(1);
    bus_write(ADDR_CAP, 32'h4);
    point(ADDR_CAP);
    chk("R9 edge wins", r0 & 32'h4, 32'h4);
    chk("R8 clear without edge", r1 & 32'h4, 32'h0);
    bus_write(ADDR_CAP, 32'h4);
    chk("R8 later clear", r0 & 32'h4, 32'h0);
  endtask

  task automatic t_irq();
    settle_clean();
    set_pins(32'h8);
    idle(4);
    point(ADDR_CAP);
    chk("R10 recorded masked", r0, 32'h8);
    chk("R10 masked quiet", {31'h0, irq0}, 32'h0);
    bus_write(ADDR_MASK, 32'h8);
    chk("R10 irq on", {31'h0, irq0}, 32'h1);
    bus_write(ADDR_CAP, 32'h8);
    chk("R10 irq off", {31'h0, irq0}, 32'h0);
  endtask

  task automatic t_level();
    settle_clean();
    bus_write(ADDR_DIR, 32'h0);
    bus_write(ADDR_MASK, 32'h10);
    set_pins(32'h10);
    idle(1);
    chk("R11 level not yet", {31'h0, irq3}, 32'h0);
    idle(1);
    chk("R11 level high", {31'h0, irq3}, 32'h1);
    point(ADDR_CAP);
    chk("R11 no capture", r3, 32'h0);
    bus_write(ADDR_CAP, 32'hFF);
    chk("R11 still high", {31'h0, irq3}, 32'h1);
    set_pins(32'h0);
    idle(2);
    chk("R11 level low", {31'h0, irq3}, 32'h0);
    bus_write(ADDR_DATA, 32'h10);
    bus_write(ADDR_DIR, 32'h10);
    chk("R11 output view", {31'h0, irq3}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd0;
    bus_wdata = 32'h0; pin_in = 32'h0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_dir_out();
    t_readback();
    t_mask();
    t_edges();
    t_race();
    t_irq();
    t_level();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule